// File: doc/BRIEF.md
# SPI Register Command Decoder

This block is the peripheral-side front end of a serial control port. A host frames each transaction with an active-low chip select. In SPI mode 0 it sends a command byte and then one data byte. The block brings the serial pins into its own clock domain and assembles the two bytes. It then applies one of three write-type operations to a banked register file of 8-bit registers. The three operations are a plain store, an atomic OR (bit set) and an atomic AND-NOT (bit clear). The set and clear operations let firmware change single flags without first reading the register back.

The register space seen from the port is 32 addresses wide. The lower addresses are banked, and a 2-bit bank selector picks one of four copies of them. The top five addresses are shared by all banks. The shared register at the highest address holds the bank selector in its two least significant bits, so it can be reached whatever bank is active. To change bank, a host clears both selector bits and then sets the bits it wants. The rest of the chip reads any register through a combinational peek port and sees the active bank on a dedicated output.

Top module: `spi_regcmd_top`

## Requirements
- R1: While synchronous reset is held low and after it is released, every register in all four banks and every shared register reads 0x00, and the active bank output is 0.
- R2: The port uses SPI mode 0: MOSI is sampled on the rising SCK edge while chip select is low, and bits arrive MSB first. The first 8 bits form the command: bits [7:5] are the opcode and bits [4:0] the register address. The next 8 bits are the data byte.
- R3: Opcode 3'b010 (store) writes the data byte to the addressed register. An address below 27 (0x1B) selects the register in the active bank. Addresses 27 to 31 select the shared registers.
- R4: Opcode 3'b100 (bit set) leaves a shared register equal to its old value OR the data byte.
- R5: Opcode 3'b101 (bit clear) leaves a shared register equal to its old value AND the inverse of the data byte.
- R6: Bit set and bit clear aimed at a banked address (below 27) change no register.
- R7: The opcodes 3'b000, 3'b001, 3'b011, 3'b110 and 3'b111 change no register.
- R8: If chip select rises before the 16th rising SCK edge of a frame, no register changes.
- R9: Bits [1:0] of the shared register at address 31 (0x1F) select the active bank. That register and the other shared registers read the same value through the peek port for every bank number.
- R10: Each chip-select frame applies at most one operation. SCK edges after the 16th one in the same frame have no effect.
- R11: The update caused by the 16th rising SCK edge is visible on the peek port and the bank output exactly four clock edges after the SCK rise is presented at the pins: two synchronizer stages, one edge-detect and shift stage, and one register-file stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the SPI pins are oversampled by it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| peek_bank | input | 2 | Bank number used by the peek port for banked addresses |
| peek_addr | input | 5 | Register address read by the peek port |
| peek_data | output | 8 | Combinational contents of the register being peeked |
| bank_sel | output | 2 | Active bank, bits [1:0] of shared register 31 |

## Verification
Two things can happen in the same clock cycle. A command can commit, and that command's own chip select can be released. The commit may also move the bank selector while the peek port is reading a banked address. To provoke the first case, the bench releases chip select one clock after the 16th SCK rise, so the release is still in the synchronizer when the frame commits. A behavioural model holds a flat four-by-32 image of the registers and applies each operation exactly four edges after the final SCK rise. The peek port sweeps every bank and address, one per clock. The peek value and the bank output are compared with the model on every clock. A bank switch therefore shows up as a mismatch if it lands early, lands late or goes to the wrong copy.

// File: rtl/spi_regcmd_pkg.sv
// Package: spi_regcmd_pkg
// Shared widths, opcode codes and the decoded command record for the SPI
// register command decoder. Assumes an 8-bit command and an 8-bit data byte.
package spi_regcmd_pkg;

    localparam int OP_W      = 3;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int NUM_ADDRS = 1 << ADDR_W;
    localparam int FRAME_BITS = OP_W + ADDR_W + DATA_W;

    localparam logic [OP_W-1:0] OPC_STORE = 3'b010;
    localparam logic [OP_W-1:0] OPC_BSET  = 3'b100;
    localparam logic [OP_W-1:0] OPC_BCLR  = 3'b101;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } regcmd_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings a vector of asynchronous pins into the clk domain through a chain
// of STAGES flops. Assumes each pin changes slowly compared with clk, so a
// lone bit may resolve one cycle late without breaking framing.
module spi_pin_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture of the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= pins_in;
            end
        end else begin : g_next
            // Purpose: further settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign pins_sync = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_shifter.sv
// Module: spi_frame_shifter
// Detects rising SCK edges on the synchronized pins and shifts MOSI in MSB
// first while chip select is low. On the FRAME_BITS-th edge it emits a
// one-cycle command strobe with the assembled record. Further edges in the
// same frame are ignored. A frame that closes early is dropped. Assumes the
// inputs are already in the clk domain.
module spi_frame_shifter
    import spi_regcmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sck_s,
    input  logic    cs_n_s,
    input  logic    mosi_s,
    output logic    cmd_valid,
    output regcmd_t cmd
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    logic                  sck_prev;
    logic                  sck_rise;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  strobe_q;

    assign sck_rise = sck_s & ~sck_prev;

    // Purpose: remember last SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Purpose: count and shift frame bits, raise the strobe on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sck_rise && bit_cnt != CNT_FULL) begin
                shreg   <= {shreg[FRAME_BITS-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST) strobe_q <= 1'b1;
            end
        end
    end

    assign cmd_valid = strobe_q;
    assign cmd       = regcmd_t'(shreg);

    // R10: the bit counter never runs past one frame.
    assert_cnt_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL);

    // R10: a strobe is never followed by a second one in the next cycle.
    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);

    // R8: a strobe only follows a cycle in which chip select was low.
    assert_strobe_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> $past(!cs_n_s));

endmodule

// File: rtl/spi_bank_regfile.sv
// Module: spi_bank_regfile
// Holds NUM_BANKS copies of the banked registers (addresses below
// SHARED_BASE) and one copy of the shared registers (SHARED_BASE and up).
// It applies store, bit-set and bit-clear commands. Bit operations act on
// shared registers only. The bank selector lives in the low bits of the
// shared register at BANK_ADDR. Reads are combinational.
module spi_bank_regfile
    import spi_regcmd_pkg::*;
#(
    parameter int SHARED_BASE = 27,
    parameter int BANK_ADDR   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  regcmd_t           cmd,
    input  logic [BANK_W-1:0] peek_bank,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [BANK_W-1:0] bank_sel
);

    localparam int NUM_SHARED = NUM_ADDRS - SHARED_BASE;
    localparam int SIDX_W     = $clog2(NUM_SHARED);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SHARED_BASE);
    localparam logic [SIDX_W-1:0] BANK_IDX = SIDX_W'(BANK_ADDR - SHARED_BASE);

    logic [DATA_W-1:0]                   banked_q [NUM_BANKS][SHARED_BASE];
    logic [NUM_SHARED-1:0][DATA_W-1:0]   shared_q;

    logic              cmd_shared;
    logic [SIDX_W-1:0] cmd_sidx;
    logic [ADDR_W-1:0] cmd_off;
    logic              peek_shared;
    logic [ADDR_W-1:0] peek_off;
    logic [SIDX_W-1:0] peek_sidx;
    logic              do_store;
    logic              do_bset;
    logic              do_bclr;

    // Purpose: classify the incoming command.
    always_comb begin
        cmd_shared = (cmd.addr >= BASE_A);
        cmd_off    = cmd.addr - BASE_A;
        cmd_sidx   = cmd_off[SIDX_W-1:0];
        do_store   = cmd_valid && (cmd.op == OPC_STORE);
        do_bset    = cmd_valid && (cmd.op == OPC_BSET) && cmd_shared;
        do_bclr    = cmd_valid && (cmd.op == OPC_BCLR) && cmd_shared;
    end

    assign bank_sel = shared_q[BANK_IDX][BANK_W-1:0];

    // Purpose: update the shared registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_q <= '0;
        end else if (cmd_shared) begin
            if (do_store)      shared_q[cmd_sidx] <= cmd.data;
            else if (do_bset)  shared_q[cmd_sidx] <= shared_q[cmd_sidx] | cmd.data;
            else if (do_bclr)  shared_q[cmd_sidx] <= shared_q[cmd_sidx] & ~cmd.data;
        end
    end

    // Purpose: store into the active bank's copy of a banked register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int a = 0; a < SHARED_BASE; a++) begin
                    banked_q[b][a] <= '0;
                end
            end
        end else if (do_store && !cmd_shared) begin
            banked_q[bank_sel][cmd.addr] <= cmd.data;
        end
    end

    // Purpose: combinational peek of any register.
    always_comb begin
        peek_shared = (peek_addr >= BASE_A);
        peek_off    = peek_addr - BASE_A;
        peek_sidx   = peek_off[SIDX_W-1:0];
        if (peek_shared) peek_data = shared_q[peek_sidx];
        else             peek_data = banked_q[peek_bank][peek_addr];
    end

    // R4: after a bit set, every requested bit reads as one.
    assert_bset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd.op == OPC_BSET && cmd_shared)
        |=> ((shared_q[$past(cmd_sidx)] & $past(cmd.data)) == $past(cmd.data)));

    // R5: after a bit clear, every requested bit reads as zero.
    assert_bclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd.op == OPC_BCLR && cmd_shared)
        |=> ((shared_q[$past(cmd_sidx)] & $past(cmd.data)) == '0));

    // R7: an undefined opcode leaves the shared registers untouched.
    assert_bad_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd.op != OPC_STORE && cmd.op != OPC_BSET && cmd.op != OPC_BCLR)
        |=> $stable(shared_q));

    // R9: the bank only moves when a command has been applied.
    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(bank_sel));

    // R6: a bit operation at a banked address leaves shared registers alone.
    assert_banked_bitop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_shared && cmd.op != OPC_STORE) |=> $stable(shared_q));

endmodule

// File: rtl/spi_regcmd_top.sv
// Module: spi_regcmd_top
// SPI mode-0 register command decoder. Synchronizes the pins, assembles a
// command/data frame and applies it to a four-bank register file. Assumes
// SCK is at most a quarter of the clk rate so each level is seen twice.
module spi_regcmd_top
    import spi_regcmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHARED_BASE = 27,
    parameter int BANK_ADDR   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [BANK_W-1:0] peek_bank,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [BANK_W-1:0] bank_sel
);

    logic [2:0] pins_s;
    logic       cmd_valid;
    regcmd_t    cmd;

    spi_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_in   ({spi_cs_n, spi_sck, spi_mosi}),
        .pins_sync (pins_s)
    );

    spi_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .mosi_s    (pins_s[0]),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    spi_bank_regfile #(
        .SHARED_BASE (SHARED_BASE),
        .BANK_ADDR   (BANK_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .peek_bank (peek_bank),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .bank_sel  (bank_sel)
    );

endmodule

// File: tb/spi_regcmd_top_tb.sv
// Bench: drives SPI frames, keeps a behavioural register image, and compares
// the peek port and bank output with it on every clock.
module spi_regcmd_top_tb_top;

    localparam int HALF    = 4;
    localparam int LAT     = 4;
    localparam int WDOG    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic [1:0] peek_bank = 2'd0;
    logic [4:0] peek_addr = 5'd0;
    logic [7:0] peek_data;
    logic [1:0] bank_sel;

    always #4 clk = ~clk;

    spi_regcmd_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .peek_bank (peek_bank),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .bank_sel  (bank_sel)
    );

    int    mem [4][32];
    int    due_q[$];
    int    op_q[$];
    int    adr_q[$];
    int    dat_q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Model of one operation, written from the requirements.
    function automatic void model_apply(int op, int a, int d);
        int bk;
        bk = mem[0][31] & 3;
        if (op == 2) begin
            if (a >= 27) for (int b = 0; b < 4; b++) mem[b][a] = d;
            else mem[bk][a] = d;
        end else if (op == 4 && a >= 27) begin
            for (int b = 0; b < 4; b++) mem[b][a] = mem[b][a] | d;
        end else if (op == 5 && a >= 27) begin
            for (int b = 0; b < 4; b++) mem[b][a] = mem[b][a] & (~d & 255);
        end
    endfunction

    // Per-clock compare of the peek port and bank output against the model.
    always @(posedge clk) begin
        cyc = cyc + 1;
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            model_apply(op_q[0], adr_q[0], dat_q[0]);
            void'(due_q.pop_front());
            void'(op_q.pop_front());
            void'(adr_q.pop_front());
            void'(dat_q.pop_front());
        end
        #2;
        if (cmp_en) begin
            n_cmp++;
            if (int'(peek_data) != mem[peek_bank][peek_addr] ||
                int'(bank_sel) != (mem[0][31] & 3)) begin
                n_bad++;
                $display("FAIL %s bank%0d addr%0h: actual data=%02h bank=%0d expected data=%02h bank=%0d",
                         cur_req, peek_bank, peek_addr, peek_data, bank_sel,
                         mem[peek_bank][peek_addr], mem[0][31] & 3);
            end
        end
    end

    // Sweep the peek port across all banks and addresses.
    always @(negedge clk) begin
        {peek_bank, peek_addr} <= {peek_bank, peek_addr} + 7'd1;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one frame of nbits bits, MSB first; fast_end releases CS early.
    task automatic frame(input logic [15:0] w, input int nbits, input bit fast_end);
        spi_cs_n = 1'b0;
        tick(2);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = (i < 16) ? w[15-i] : 1'b1;
            tick(HALF);
            spi_sck = 1'b1;
            if (i == 15) begin
                due_q.push_back(cyc + LAT);
                op_q.push_back(int'(w[15:13]));
                adr_q.push_back(int'(w[12:8]));
                dat_q.push_back(int'(w[7:0]));
            end
            if (fast_end && i == nbits - 1) tick(1);
            else tick(HALF);
        end
        spi_sck  = 1'b0;
        spi_cs_n = 1'b1;
        tick(8);
    endtask

    function automatic logic [15:0] cw(int op, int a, int d);
        return {3'(op), 5'(a), 8'(d)};
    endfunction

    initial begin
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) mem[b][a] = 0;
        tick(2);
        cmp_en = 1'b1;          // R1: reset values compared while reset held
        tick(4);
        rst_n = 1'b1;
        tick(200);              // R1: values after release

        cur_req = "R2/R3 store shared";
        frame(cw(2, 27, 8'hA5), 16, 0);
        frame(cw(2, 30, 8'h3C), 16, 0);
        cur_req = "R4 bit set";
        frame(cw(4, 27, 8'h0F), 16, 0);
        cur_req = "R5 bit clear";
        frame(cw(5, 27, 8'h81), 16, 0);
        cur_req = "R9 bank change clear+set";
        frame(cw(5, 31, 8'h03), 16, 0);
        frame(cw(4, 31, 8'h02), 16, 0);
        cur_req = "R3 store banked bank2";
        frame(cw(2, 5, 8'h3C), 16, 0);
        frame(cw(2, 0, 8'h11), 16, 0);
        cur_req = "R9 bank via store";
        frame(cw(2, 31, 8'hF1), 16, 0);
        cur_req = "R3 store banked bank1";
        frame(cw(2, 5, 8'hC3), 16, 0);
        frame(cw(2, 26, 8'h7E), 16, 0);
        cur_req = "R6 bit op banked";
        frame(cw(4, 5, 8'hFF), 16, 0);
        frame(cw(5, 26, 8'hFF), 16, 0);
        cur_req = "R7 undefined opcodes";
        frame(cw(0, 27, 8'hFF), 16, 0);
        frame(cw(1, 27, 8'hFF), 16, 0);
        frame(cw(3, 28, 8'hFF), 16, 0);
        frame(cw(6, 31, 8'h03), 16, 0);
        frame(cw(7, 5, 8'h00), 16, 0);
        cur_req = "R8 early release";
        frame(cw(2, 28, 8'hFF), 10, 0);
        frame(cw(2, 31, 8'h03), 15, 0);
        cur_req = "R10 extra bits";
        frame(cw(2, 29, 8'h55), 20, 0);
        frame(cw(4, 29, 8'h80), 24, 0);
        cur_req = "R11 release right after last edge";
        frame(cw(2, 31, 8'h03), 16, 1);
        frame(cw(2, 7, 8'h99), 16, 1);
        cur_req = "R9 shared seen from all banks";
        frame(cw(2, 28, 8'h5A), 16, 0);
        frame(cw(5, 31, 8'h03), 16, 0);
        frame(cw(2, 7, 8'h66), 16, 0);
        tick(300);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog %s: actual=timeout expected=completion", cur_req);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule